// File: doc/BRIEF.md
# Key-Unlocked Indexed Configuration Port

This block provides a configuration space reached through a two-byte window on a simple byte-wide bus. One address bit picks between two ports. Port 0 takes register indices. Port 1 reads and writes the register that the last index names. While the block is locked, the whole space is hidden. To open it, software writes an entry key to port 0 twice in a row. A different key written to port 0 locks the space again.

Once the space is open, it has two parts. Indices below 0x30 are shared by all logical devices: a logical-device select register, identification bytes for the device and the vendor, and a revision byte. Indices 0x30 and above are banked. Each logical device has its own copy of an enable bit, a 16-bit base address and a small scratch window. The selected device is the one whose copy a port-1 access reaches. Each device's enable bit and base address also drive output pins, so the functions that use them can read them directly.

The bus has no back-pressure. Every write strobe takes effect at the clock edge on which it is sampled. A read strobe loads the read-data register at that edge, so the data is valid in the following cycle and stays there until the next read.

Top module: `keyport_cfg`

## Requirements
- R1: After reset the port is locked, the stored index and the device select are 0, every device enable and base address is 0, and the read data register holds 0xFF.
- R2: Two port-0 writes of 0x87 in a row open configuration mode. `cfg_mode` rises at the edge of the second write.
- R3: If a single port-0 write of 0x87 is followed by a port-0 write of any other value, the entry sequence returns to its start. After that, one further 0x87 does not open the port. Port-1 accesses do not break the sequence.
- R4: In configuration mode, a port-0 write of 0xAA leaves configuration mode and is not stored as an index.
- R5: While the port is not in configuration mode, reads of either port return 0xFF, and port-1 writes change no register.
- R6: In configuration mode, a port-0 write stores its value as the index, except for the value 0xAA. A port-0 read returns the stored index. A read strobe loads the read data register at the edge on which it is sampled.
- R7: Index 0x20 returns the device ID high byte and 0x21 the low byte (0x5A and 0x41 by default). Index 0x22 returns the revision (0x03). Index 0x23 returns the vendor high byte 0x19 and 0x24 the low byte 0x34. Writes to these indices have no effect.
- R8: Index 0x07 is the read/write device select. Banked indices (0x30 and above) reach only the copy that belongs to the selected device.
- R9: Index 0x30 bit 0 is the enable of the selected device and drives bit n of `dev_en` for device n. The other bits of this register read as 0.
- R10: Indices 0x60 and 0x61 hold the high and low bytes of the selected device's base address. Device n's base address appears on `dev_base[16n+15:16n]`.
- R11: Indices 0xF0 to 0xFF form a read/write scratch window for each device.
- R12: When the select register names a device at or above `NUM_DEV`, banked reads return 0x00 and banked writes are ignored. Any index with no register behind it reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cfg_mode | output | 1 | High while configuration mode is open |
| dev_sel | output | 8 | Current logical-device select |
| dev_en | output | NUM_DEV | Enable bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device 0 in the low bits |

## Verification
The hardest case to reach is a broken entry sequence, where the port must end up one key short of opening. The port looks the same from outside whether it is locked or half-unlocked, so reading the state right after the break shows nothing. The stimulus therefore writes the first key, then a stray value, then the key once more, and reads port 1. The read must return 0xFF, because a design that ignored the break would already be open. A final key then opens the port, and a read of the select register shows that an earlier locked write to port 1 had no effect.

// File: rtl/keyport_pkg.sv
package keyport_pkg;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_ENTER   = 8'h87;
  localparam logic [7:0] KEY_EXIT    = 8'hAA;
  localparam logic [7:0] IX_SELECT   = 8'h07;
  localparam logic [7:0] IX_DEVID_HI = 8'h20;
  localparam logic [7:0] IX_DEVID_LO = 8'h21;
  localparam logic [7:0] IX_REV      = 8'h22;
  localparam logic [7:0] IX_VEND_HI  = 8'h23;
  localparam logic [7:0] IX_VEND_LO  = 8'h24;
  localparam logic [7:0] IX_BANK_LO  = 8'h30;
  localparam logic [7:0] IX_ENABLE   = 8'h30;
  localparam logic [7:0] IX_BASE_HI  = 8'h60;
  localparam logic [7:0] IX_BASE_LO  = 8'h61;
  localparam logic [7:0] RD_LOCKED   = 8'hFF;

endpackage

// File: rtl/keyport_unlock.sv
module keyport_unlock
  import keyport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr_i,
  input  logic [7:0] wdata_i,
  output logic       open_o
);

  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        KS_LOCKED: state_d = (wdata_i == KEY_ENTER) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (wdata_i == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (wdata_i == KEY_EXIT)  ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= KS_LOCKED;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == KS_OPEN);

  // R2: opening is always the result of a second consecutive entry key
  p_open_after_two_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == KS_OPEN) |->
      $past(state_q == KS_HALF && idx_wr_i && wdata_i == KEY_ENTER));

  // R3: a stray index write after the first key falls back to the start
  p_broken_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_HALF && idx_wr_i && wdata_i != KEY_ENTER) |=> state_q == KS_LOCKED);

  // R4: the exit key always closes the port
  p_exit_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == KS_OPEN && idx_wr_i && wdata_i == KEY_EXIT) |=> !open_o);

endmodule

// File: rtl/keyport_globals.sv
module keyport_globals
  import keyport_pkg::*;
#(
  parameter logic [15:0] DEV_ID = 16'h5A41,
  parameter logic [7:0]  DEV_REV = 8'h03,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sel_o,
  output logic [7:0] rdata_o
);

  logic [7:0] sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                           sel_q <= 8'h00;
    else if (wr_i && idx_i == IX_SELECT)  sel_q <= wdata_i;
  end

  always_comb begin
    unique case (idx_i)
      IX_SELECT:   rdata_o = sel_q;
      IX_DEVID_HI: rdata_o = DEV_ID[15:8];
      IX_DEVID_LO: rdata_o = DEV_ID[7:0];
      IX_REV:      rdata_o = DEV_REV;
      IX_VEND_HI:  rdata_o = VENDOR_ID[15:8];
      IX_VEND_LO:  rdata_o = VENDOR_ID[7:0];
      default:     rdata_o = 8'h00;
    endcase
  end

  assign sel_o = sel_q;

  // R8: the select register moves only on a global write
  p_select_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(sel_q));

endmodule

// File: rtl/keyport_bank.sv
module keyport_bank
  import keyport_pkg::*;
#(
  parameter logic [7:0] SCR_BASE = 8'hF0,
  parameter int         SCR_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [7:0]  idx_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        en_o,
  output logic [15:0] base_o
);

  localparam int SCR_AW = (SCR_WORDS > 1) ? $clog2(SCR_WORDS) : 1;

  logic        en_q;
  logic [15:0] base_q;
  logic [7:0]  scr_q [SCR_WORDS];
  logic        scr_hit;
  logic [7:0]  scr_diff;
  logic [SCR_AW-1:0] scr_off;

  assign scr_diff = idx_i - SCR_BASE;
  assign scr_off  = scr_diff[SCR_AW-1:0];
  assign scr_hit  = (idx_i >= SCR_BASE) &&
                    ({1'b0, idx_i} < ({1'b0, SCR_BASE} + 9'(SCR_WORDS)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= 16'h0000;
    end else if (wr_i) begin
      if (idx_i == IX_ENABLE)  en_q          <= wdata_i[0];
      if (idx_i == IX_BASE_HI) base_q[15:8]  <= wdata_i;
      if (idx_i == IX_BASE_LO) base_q[7:0]   <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SCR_WORDS; k++) scr_q[k] <= 8'h00;
    end else if (wr_i && scr_hit) begin
      scr_q[scr_off] <= wdata_i;
    end
  end

  always_comb begin
    if (idx_i == IX_ENABLE)       rdata_o = {7'b0, en_q};
    else if (idx_i == IX_BASE_HI) rdata_o = base_q[15:8];
    else if (idx_i == IX_BASE_LO) rdata_o = base_q[7:0];
    else if (scr_hit)             rdata_o = scr_q[scr_off];
    else                          rdata_o = 8'h00;
  end

  assign en_o   = en_q;
  assign base_o = base_q;

  // R9, R10: a bank that is not written keeps its enable and base address
  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(en_q) && $stable(base_q)));

endmodule

// File: rtl/keyport_cfg.sv
module keyport_cfg
  import keyport_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter int          SCR_WORDS = 16,
  parameter logic [7:0]  SCR_BASE  = 8'hF0,
  parameter logic [15:0] DEV_ID    = 16'h5A41,
  parameter logic [7:0]  DEV_REV   = 8'h03,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_addr,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [7:0]            bus_wdata,
  output logic [7:0]            bus_rdata,
  output logic                  cfg_mode,
  output logic [7:0]            dev_sel,
  output logic [NUM_DEV-1:0]    dev_en,
  output logic [NUM_DEV*16-1:0] dev_base
);

  localparam int DEV_AW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic       open;
  logic       idx_wr, dat_wr;
  logic [7:0] index_q;
  logic       is_global;
  logic       sel_ok;
  logic [7:0] sel;
  logic [7:0] glob_rd;
  logic [7:0] rd_val;
  logic [7:0] rdata_q;
  logic [7:0] bank_rd [NUM_DEV];

  assign idx_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr &&  bus_addr;

  keyport_unlock u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr_i (idx_wr),
    .wdata_i  (bus_wdata),
    .open_o   (open)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      index_q <= 8'h00;
    else if (open && idx_wr && bus_wdata != KEY_EXIT)
      index_q <= bus_wdata;
  end

  assign is_global = (index_q < IX_BANK_LO);

  keyport_globals #(
    .DEV_ID    (DEV_ID),
    .DEV_REV   (DEV_REV),
    .VENDOR_ID (VENDOR_ID)
  ) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (open && dat_wr && is_global),
    .idx_i   (index_q),
    .wdata_i (bus_wdata),
    .sel_o   (sel),
    .rdata_o (glob_rd)
  );

  assign sel_ok = ({24'd0, sel} < 32'(NUM_DEV));

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_bank
    logic        en_w;
    logic [15:0] base_w;
    keyport_bank #(
      .SCR_BASE  (SCR_BASE),
      .SCR_WORDS (SCR_WORDS)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (open && dat_wr && !is_global && ({24'd0, sel} == 32'(i))),
      .idx_i   (index_q),
      .wdata_i (bus_wdata),
      .rdata_o (bank_rd[i]),
      .en_o    (en_w),
      .base_o  (base_w)
    );
    assign dev_en[i]             = en_w;
    assign dev_base[i*16 +: 16]  = base_w;
  end

  always_comb begin
    if (!open)          rd_val = RD_LOCKED;
    else if (!bus_addr) rd_val = index_q;
    else if (is_global) rd_val = glob_rd;
    else if (sel_ok)    rd_val = bank_rd[sel[DEV_AW-1:0]];
    else                rd_val = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= RD_LOCKED;
    else if (bus_rd) rdata_q <= rd_val;
  end

  assign bus_rdata = rdata_q;
  assign cfg_mode  = open;
  assign dev_sel   = sel;

  // R5: a read while locked returns all ones
  p_locked_read_ff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_mode) |=> bus_rdata == 8'hFF);

  // R5: a data write while locked leaves every register untouched
  p_locked_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && !cfg_mode) |=> ($stable(dev_sel) && $stable(dev_en) && $stable(dev_base)));

  // R6: the index changes only through an index-port write
  p_index_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(index_q));

  // R6: read data holds between read strobes
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_keyport_cfg.sv
module sim_keyport_cfg;

  localparam int NUM_DEV = 8;

  typedef struct packed {
    logic       port;
    logic       wr;
    logic       rd;
    logic [7:0] dat;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t W(input logic p, input logic [7:0] d, input logic [3:0] r);
    return '{port: p, wr: 1'b1, rd: 1'b0, dat: d, exp: 8'h00, req: r};
  endfunction

  function automatic vec_t R(input logic p, input logic [7:0] e, input logic [3:0] r);
    return '{port: p, wr: 1'b0, rd: 1'b1, dat: 8'h00, exp: e, req: r};
  endfunction

  localparam int NV = 62;
  localparam vec_t VEC [NV] = '{
    W(0, 8'h87, 2), W(0, 8'h87, 2),                                   // R2 open
    W(0, 8'h20, 7), R(1, 8'h5A, 7), W(0, 8'h21, 7), R(1, 8'h41, 7),   // R7 ids
    W(0, 8'h22, 7), R(1, 8'h03, 7), W(0, 8'h23, 7), R(1, 8'h19, 7),
    W(0, 8'h24, 7), R(1, 8'h34, 7), W(1, 8'hFF, 7), R(1, 8'h34, 7),
    R(0, 8'h24, 6),                                                   // R6 index readback
    W(0, 8'h07, 8), W(1, 8'h03, 8), R(1, 8'h03, 8),                   // R8 select
    W(0, 8'h30, 9), W(1, 8'hFF, 9), R(1, 8'h01, 9),                   // R9 enable
    W(0, 8'h60, 10), W(1, 8'h12, 10), W(0, 8'h61, 10), W(1, 8'h34, 10),
    R(1, 8'h34, 10), W(0, 8'h60, 10), R(1, 8'h12, 10),                // R10 base
    W(0, 8'hF5, 11), W(1, 8'hA5, 11), R(1, 8'hA5, 11),                // R11 scratch
    W(0, 8'h07, 8), W(1, 8'h05, 8), W(0, 8'hF5, 8), R(1, 8'h00, 8),   // R8 banking
    W(0, 8'h30, 8), R(1, 8'h00, 8),
    W(0, 8'h07, 8), W(1, 8'h03, 8), W(0, 8'hF5, 11), R(1, 8'hA5, 11),
    W(0, 8'h07, 12), W(1, 8'h09, 12), W(0, 8'h30, 12), W(1, 8'h01, 12), // R12
    R(1, 8'h00, 12), W(0, 8'h40, 12), R(1, 8'h00, 12),
    W(0, 8'h07, 4), W(1, 8'h03, 4), W(0, 8'hAA, 4),                   // R4 exit
    R(1, 8'hFF, 5), R(0, 8'hFF, 5), W(1, 8'h00, 5),                   // R5 locked
    W(0, 8'h87, 3), W(0, 8'h55, 3), W(0, 8'h87, 3), R(1, 8'hFF, 3),   // R3 broken key
    W(0, 8'h87, 3), R(1, 8'h03, 5), W(0, 8'h30, 9), R(1, 8'h01, 9)
  };

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  bus_addr = 1'b0;
  logic                  bus_wr = 1'b0;
  logic                  bus_rd = 1'b0;
  logic [7:0]            bus_wdata = 8'h00;
  logic [7:0]            bus_rdata;
  logic                  cfg_mode;
  logic [7:0]            dev_sel;
  logic [NUM_DEV-1:0]    dev_en;
  logic [NUM_DEV*16-1:0] dev_base;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyport_cfg #(.NUM_DEV(NUM_DEV)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg_mode  (cfg_mode),
    .dev_sel   (dev_sel),
    .dev_en    (dev_en),
    .dev_base  (dev_base)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic p, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = p;
    bus_wr    = w;
    bus_rd    = r;
    bus_wdata = d;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    // R1 reset state
    check({15'd0, cfg_mode}, 16'd0, 1, "cfg_mode after reset");
    check({8'd0, bus_rdata}, 16'h00FF, 1, "rdata after reset");
    check({8'd0, dev_en}, 16'd0, 1, "dev_en after reset");

    for (int n = 0; n < NV; n++) begin
      op(VEC[n].port, VEC[n].wr, VEC[n].rd, VEC[n].dat);
      if (VEC[n].rd)
        check({8'd0, bus_rdata}, {8'd0, VEC[n].exp}, int'(VEC[n].req),
              $sformatf("vector %0d", n));
    end

    // R2, R8, R9, R10, R12 pin-level state
    check({15'd0, cfg_mode}, 16'd1, 2, "cfg_mode reopened");
    check({8'd0, dev_sel}, 16'h0003, 8, "dev_sel");
    check({8'd0, dev_en}, 16'h0008, 9, "dev_en only device 3");
    check(dev_base[3*16 +: 16], 16'h1234, 10, "device 3 base");
    check(dev_base[5*16 +: 16], 16'h0000, 10, "device 5 base untouched");

    // R4 exit drops the mode pin
    op(1'b0, 1'b1, 1'b0, 8'hAA);
    check({15'd0, cfg_mode}, 16'd0, 4, "cfg_mode after exit key");

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    check({8'd0, dev_en}, 16'd0, 1, "dev_en after second reset");
    check(dev_base[3*16 +: 16], 16'h0000, 1, "base after second reset");
    check({8'd0, dev_sel}, 16'd0, 1, "dev_sel after second reset");
    check({8'd0, bus_rdata}, 16'h00FF, 1, "rdata after second reset");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule